// File: doc/BRIEF.md
# Serial Configuration Word Loader

This block takes configuration words from a host over a three-wire serial link: a serial clock, a data line and a load strobe. It brings all three lines into the system clock domain and shifts data in on each rising edge of the serial clock. The most significant bit comes first. A rising edge on the load strobe copies the assembled word into one of three holding latches. The two lowest bits of the word select the latch: the control latch, the feedback (N) divider latch or the reference (R) divider latch.

The held words drive parallel field outputs used by the rest of the synthesizer:
- prescaler ratio select and power-down mode, from the control latch;
- charge pump gain select, B count and A count, from the N latch;
- reference count, from the R latch.

Every load into the N latch also raises a band-select request for exactly one system clock. The oscillator calibration logic uses this request to pick a new band after a channel change. A host can send a word as three bytes while the strobe is low, then raise the strobe.

Top module: `cfg_serial_latches`

## Requirements
- R1: Serial data is shifted in on each rising edge of the serial clock, as seen after synchronisation, with bit 23 sent first. Only the last 24 bits shifted before a load are kept.
- R2: A rising edge of the load strobe copies the shift word into one latch, chosen by bits [1:0]: 2'b00 selects control, 2'b10 selects N and 2'b01 selects R. The other two latches keep their contents.
- R3: A load whose bits [1:0] are 2'b11 changes none of the three latches and raises no band-select request.
- R4: Rising edges of the serial clock while the load strobe is high do not shift the word.
- R5: The control fields come from these bits: prescaler select is bits [23:22] and power-down mode is bits [21:20].
- R6: The N fields come from these bits: charge pump gain select is bit 21 (1 selects current setting 2, 0 selects current setting 1), B count is bits [20:8] and A count is bits [6:2].
- R7: The R field is the reference count in bits [15:2].
- R8: Each load into the N latch raises band_req_o for exactly one system clock. Loads into the other latches raise no request.
- R9: After reset, all latches, all fields and band_req_o are zero.
- R10: Each input passes through a two-flop synchroniser. A load strobe edge that has settled before system clock edge k shows on the latch outputs after edge k+2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Serial clock from host (asynchronous) |
| sdata_i | input | 1 | Serial data from host (asynchronous) |
| sle_i | input | 1 | Load strobe from host (asynchronous) |
| ctrl_latch_o | output | 24 | Held control word |
| n_latch_o | output | 24 | Held N divider word |
| r_latch_o | output | 24 | Held R divider word |
| prescale_sel_o | output | 2 | Prescaler ratio select |
| pwrdn_mode_o | output | 2 | Power-down mode bits |
| cp_gain_sel_o | output | 1 | Charge pump gain select |
| ndiv_b_o | output | 13 | B count |
| ndiv_a_o | output | 5 | A count |
| rdiv_o | output | 14 | Reference count |
| band_req_o | output | 1 | One-cycle band-select request |

## Verification
The assertions check four properties on every cycle:
- the band-select request never lasts past one clock;
- no load changes more than one latch;
- a load with the unused code leaves all latches unchanged;
- the shift word holds while the strobe is high, and the newest bit lands at the bottom.

Other behaviours show only through the bench's scenarios against its behavioural model:
- the most-significant-first bit order;
- the field positions for each latch;
- the three-clock load latency;
- one request per N write and none for other writes;
- a reload with no new clocks after ignored serial clock edges.

// File: rtl/cfgser_pkg.sv
package cfgser_pkg;
  localparam int WORD_W = 24;
  localparam int SEL_W  = 2;

  typedef enum logic [SEL_W-1:0] {
    SEL_CTRL = 2'b00,
    SEL_RDIV = 2'b01,
    SEL_NDIV = 2'b10,
    SEL_NONE = 2'b11
  } latch_sel_e;

  // field positions
  localparam int PRE_HI = 23, PRE_LO = 22;
  localparam int PD_HI  = 21, PD_LO  = 20;
  localparam int CPG_B  = 21;
  localparam int NB_HI  = 20, NB_LO  = 8;
  localparam int NA_HI  = 6,  NA_LO  = 2;
  localparam int RC_HI  = 15, RC_LO  = 2;
endpackage

// File: rtl/cfgser_sync.sv
module cfgser_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    logic [W-1:0] r_q;
    logic [W-1:0] r_d;
    if (g == 0) begin : g_first
      assign r_d = d_i;
    end else begin : g_next
      assign r_d = g_stage[g-1].r_q;
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) r_q <= '0;
      else         r_q <= r_d;
    end
  end

  assign q_o = g_stage[STAGES-1].r_q;
endmodule

// File: rtl/cfgser_shift.sv
module cfgser_shift #(
  parameter int W = cfgser_pkg::WORD_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         sclk_s_i,
  input  logic         data_s_i,
  input  logic         le_s_i,
  output logic [W-1:0] word_o,
  output logic         load_o
);
  logic         sclk_p_q, le_p_q;
  logic [W-1:0] sreg_q, sreg_d;
  logic         shift_en;

  assign shift_en = sclk_s_i & ~sclk_p_q & ~le_s_i;
  assign load_o   = le_s_i & ~le_p_q;
  assign word_o   = sreg_q;

  always_comb begin
    sreg_d = sreg_q;
    if (shift_en) sreg_d = {sreg_q[W-2:0], data_s_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sreg_q   <= '0;
      sclk_p_q <= 1'b0;
      le_p_q   <= 1'b0;
    end else begin
      sreg_q   <= sreg_d;
      sclk_p_q <= sclk_s_i;
      le_p_q   <= le_s_i;
    end
  end

  // R4: word frozen while strobe is high
  a_r4_hold_le_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    le_s_i |=> $stable(sreg_q));

  // R1: new bit enters at the bottom
  a_r1_new_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sclk_s_i && !sclk_p_q && !le_s_i) |=> (sreg_q[0] == $past(data_s_i)));
endmodule

// File: rtl/cfgser_route.sv
module cfgser_route
  import cfgser_pkg::*;
#(
  parameter int W = WORD_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] word_i,
  output logic [W-1:0] ctrl_o,
  output logic [W-1:0] ndiv_o,
  output logic [W-1:0] rdiv_o,
  output logic         band_o
);
  logic [W-1:0] ctrl_q, ctrl_d, ndiv_q, ndiv_d, rdiv_q, rdiv_d;
  logic         band_q, band_d;
  latch_sel_e   sel;

  assign sel = latch_sel_e'(word_i[SEL_W-1:0]);

  always_comb begin
    ctrl_d = ctrl_q;
    ndiv_d = ndiv_q;
    rdiv_d = rdiv_q;
    band_d = 1'b0;
    if (load_i) begin
      unique case (sel)
        SEL_CTRL: ctrl_d = word_i;
        SEL_NDIV: begin
          ndiv_d = word_i;
          band_d = 1'b1;
        end
        SEL_RDIV: rdiv_d = word_i;
        SEL_NONE: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      ndiv_q <= '0;
      rdiv_q <= '0;
      band_q <= 1'b0;
    end else begin
      ctrl_q <= ctrl_d;
      ndiv_q <= ndiv_d;
      rdiv_q <= rdiv_d;
      band_q <= band_d;
    end
  end

  assign ctrl_o = ctrl_q;
  assign ndiv_o = ndiv_q;
  assign rdiv_o = rdiv_q;
  assign band_o = band_q;

  // R8: request lasts one clock
  a_r8_band_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    band_q |=> !band_q);

  // R3: unused code leaves latches alone
  a_r3_ignore_code3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && word_i[1:0] == 2'b11) |=>
      ($stable(ctrl_q) && $stable(ndiv_q) && $stable(rdiv_q) && !band_q));

  // R2: at most one latch changes per clock
  a_r2_one_latch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({ctrl_q != $past(ctrl_q), ndiv_q != $past(ndiv_q),
                rdiv_q != $past(rdiv_q)}) <= 1);
endmodule

// File: rtl/cfg_serial_latches.sv
module cfg_serial_latches
  import cfgser_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_i,
  input  logic              sdata_i,
  input  logic              sle_i,
  output logic [WORD_W-1:0] ctrl_latch_o,
  output logic [WORD_W-1:0] n_latch_o,
  output logic [WORD_W-1:0] r_latch_o,
  output logic [1:0]        prescale_sel_o,
  output logic [1:0]        pwrdn_mode_o,
  output logic              cp_gain_sel_o,
  output logic [12:0]       ndiv_b_o,
  output logic [4:0]        ndiv_a_o,
  output logic [13:0]       rdiv_o,
  output logic              band_req_o
);
  localparam int NIN = 3;

  logic [NIN-1:0]    raw, syn;
  logic [WORD_W-1:0] word;
  logic              load;

  assign raw = {sle_i, sdata_i, sclk_i};

  cfgser_sync #(.W(NIN), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (raw),
    .q_o   (syn)
  );

  cfgser_shift #(.W(WORD_W)) u_shift (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .sclk_s_i(syn[0]),
    .data_s_i(syn[1]),
    .le_s_i  (syn[2]),
    .word_o  (word),
    .load_o  (load)
  );

  cfgser_route #(.W(WORD_W)) u_route (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(load),
    .word_i(word),
    .ctrl_o(ctrl_latch_o),
    .ndiv_o(n_latch_o),
    .rdiv_o(r_latch_o),
    .band_o(band_req_o)
  );

  assign prescale_sel_o = ctrl_latch_o[PRE_HI:PRE_LO];
  assign pwrdn_mode_o   = ctrl_latch_o[PD_HI:PD_LO];
  assign cp_gain_sel_o  = n_latch_o[CPG_B];
  assign ndiv_b_o       = n_latch_o[NB_HI:NB_LO];
  assign ndiv_a_o       = n_latch_o[NA_HI:NA_LO];
  assign rdiv_o         = r_latch_o[RC_HI:RC_LO];
endmodule

// File: tb/cfg_serial_latches_tb.sv
module cfg_serial_latches_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0, sdata = 1'b0, sle = 1'b0;
  logic [23:0] ctrl_o, n_o, r_o;
  logic [1:0]  pre_o, pd_o;
  logic        cpg_o, band_o;
  logic [12:0] b_o;
  logic [4:0]  a_o;
  logic [13:0] rc_o;

  int checks = 0, fails = 0, bandcnt = 0;
  bit done = 0;

  always #10 clk = ~clk;

  cfg_serial_latches u_dut (
    .clk_i(clk), .rst_ni(rst_n), .sclk_i(sclk), .sdata_i(sdata), .sle_i(sle),
    .ctrl_latch_o(ctrl_o), .n_latch_o(n_o), .r_latch_o(r_o),
    .prescale_sel_o(pre_o), .pwrdn_mode_o(pd_o), .cp_gain_sel_o(cpg_o),
    .ndiv_b_o(b_o), .ndiv_a_o(a_o), .rdiv_o(rc_o), .band_req_o(band_o)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // behavioural reference model
  logic [2:0]  hist[$];
  logic [23:0] m_word, m_ctrl, m_n, m_r;
  logic        m_band;

  always @(posedge clk) begin
    if (!rst_n) begin
      hist = '{3'b0, 3'b0, 3'b0, 3'b0};
      m_word = '0; m_ctrl = '0; m_n = '0; m_r = '0; m_band = 1'b0;
    end else begin
      logic [2:0] cur, prv;
      hist.push_back({sle, sdata, sclk});
      cur = hist[hist.size()-3];
      prv = hist[hist.size()-4];
      m_band = 1'b0;
      if (cur[2] && !prv[2]) begin
        case (m_word[1:0])
          2'b00: m_ctrl = m_word;
          2'b10: begin m_n = m_word; m_band = 1'b1; end
          2'b01: m_r = m_word;
          default: ;
        endcase
      end
      if (cur[0] && !prv[0] && !cur[2]) m_word = {m_word[22:0], cur[1]};
      void'(hist.pop_front());
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (band_o) bandcnt++;
      chk("R2 model ctrl", ctrl_o, m_ctrl);
      chk("R2 model n", n_o, m_n);
      chk("R2 model r", r_o, m_r);
      chk("R8 model band", band_o, m_band);
      chk("R5 model fields", {pre_o, pd_o}, {m_ctrl[23:22], m_ctrl[21:20]});
      chk("R6 model fields", {cpg_o, b_o, a_o}, {m_n[21], m_n[20:8], m_n[6:2]});
      chk("R7 model field", rc_o, m_r[15:2]);
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(logic [23:0] w);
    sle = 1'b0;
    cyc(4);
    for (int i = 23; i >= 0; i--) begin
      sdata = w[i];
      cyc(2); sclk = 1'b1;
      cyc(2); sclk = 1'b0;
      cyc(1);
    end
    sle = 1'b1;
    cyc(8);
  endtask

  localparam logic [23:0] W_CTRL = 24'hD3C5A4;
  localparam logic [23:0] W_N1   = 24'h2ABCD6;
  localparam logic [23:0] W_R    = 24'h013579;
  localparam logic [23:0] W_N2   = 24'h000102;
  localparam logic [23:0] W_BAD  = 24'hFFFFFF;

  initial begin
    int b0;
    cyc(3);
    chk("R9 reset ctrl", ctrl_o, 0);
    chk("R9 reset n", n_o, 0);
    chk("R9 reset r", r_o, 0);
    chk("R9 reset band", band_o, 0);
    rst_n = 1'b1;
    cyc(3);

    b0 = bandcnt;
    send(W_CTRL);
    chk("R5 prescale", pre_o, W_CTRL[23:22]);
    chk("R5 powerdown", pd_o, W_CTRL[21:20]);
    chk("R1 ctrl word", ctrl_o, W_CTRL);
    chk("R8 no band on ctrl", bandcnt - b0, 0);

    b0 = bandcnt;
    send(W_N1);
    chk("R6 cp gain", cpg_o, 1);
    chk("R6 B count", b_o, W_N1[20:8]);
    chk("R6 A count", a_o, W_N1[6:2]);
    chk("R8 one band on N", bandcnt - b0, 1);
    chk("R2 ctrl kept", ctrl_o, W_CTRL);

    b0 = bandcnt;
    send(W_R);
    chk("R7 ref count", rc_o, W_R[15:2]);
    chk("R2 n kept", n_o, W_N1);
    chk("R8 no band on R", bandcnt - b0, 0);

    b0 = bandcnt;
    send(W_BAD);
    chk("R3 ctrl unchanged", ctrl_o, W_CTRL);
    chk("R3 n unchanged", n_o, W_N1);
    chk("R3 r unchanged", r_o, W_R);
    chk("R3 no band", bandcnt - b0, 0);

    b0 = bandcnt;
    send(W_N2);
    chk("R6 cp gain low", cpg_o, 0);
    chk("R8 one band on second N", bandcnt - b0, 1);

    // R4: clocks while strobe high, then reload with no clocks
    send(W_CTRL);
    sdata = 1'b1;
    for (int k = 0; k < 6; k++) begin
      cyc(2); sclk = 1'b1; cyc(2); sclk = 1'b0;
    end
    cyc(2);
    b0 = bandcnt;
    sle = 1'b0; cyc(4); sle = 1'b1; cyc(8);
    chk("R4 ctrl reloaded same", ctrl_o, W_CTRL);
    chk("R4 n untouched", n_o, W_N2);
    chk("R4 no band", bandcnt - b0, 0);

    // R10: latency of a reload strobe
    sle = 1'b0; cyc(4);
    sle = 1'b1;
    send(W_R);
    sle = 1'b0; cyc(4);
    send(W_N1);
    sle = 1'b0; cyc(4);
    @(negedge clk) sle = 1'b1;
    @(negedge clk); @(negedge clk);
    chk("R10 no band before edge k+2", band_o, 0);
    @(negedge clk);
    chk("R10 band after edge k+2", band_o, 1);
    cyc(4);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule